// File: doc/BRIEF.md
# Link Frame Alignment Receiver

This block sits behind an 8B/10B decoder and decides when a serial link is aligned to its message boundaries. Every cycle it may receive one decoded byte, marked by a strobe. With the byte come two flags: one says the decoder found a code error, and one says the byte is the frame-boundary sync character. The block reports the alignment state it is in. It also raises a link-up flag, and it gives a per-byte pass enable that lets the message layer above accept traffic only while the link is aligned.

Alignment is reached in two stages. First, the block judges the byte stream in fixed-size blocks, and a run of error-free blocks shows that the stream is clean. Second, after a first sync character, the next sync character must arrive after exactly the number of bytes that one message of the current line rate implies. A run of corrupted blocks sends the block back to the unaligned state, whatever state it is in. Block size, the clean-run threshold and the corrupt-run threshold come from configuration inputs. A line-rate factor sets the message length.

Top module: `frame_sync_rx`

## Requirements
- R1: After reset, `state_o` is 0 (unaligned; the encoding is 0 unaligned, 1 hunting for a sync character, 2 checking the message length, 3 aligned), and `link_up` and `msg_pass` are 0.
- R2: A block is `cfg_block_len` strobed bytes. It is clean only if none of its bytes has `code_err` set. A zero value acts as 1.
- R3: In state 0, the clock edge that takes the final byte of the `cfg_good_blocks`-th consecutive clean block moves the state to 1. A zero threshold acts as 1.
- R4: In state 1, a strobed byte with `sync_code`=1 and `code_err`=0 moves the state to 2. A sync flag on a byte with a code error is treated as an ordinary byte.
- R5: In state 2, the block counts strobed non-sync bytes. At the next sync byte the state becomes 3 if the count equals 128*i-1, and 1 otherwise. A sync byte that comes too early or too late returns the state to 1 and does not start a new count on that byte.
- R6: The line-rate factor i is `rate_sel` when that is 1, 2 or 4, and 1 for any other value. It is sampled only while the state is 0.
- R7: From any state, the final byte of the `cfg_bad_blocks`-th consecutive corrupted block moves the state to 0. A zero threshold acts as 1.
- R8: A block whose outcome differs from the previous block's outcome ends the opposite run, so that run must start again from zero.
- R9: A partial block in progress is discarded whenever the state changes. Counting restarts with the next strobed byte.
- R10: `link_up` is 1 exactly in state 3. `msg_pass` is 1 when the state is 3, `byte_vld` is 1 and `code_err` is 0.
- R11: Cycles with `byte_vld`=0 change nothing, whatever the other flags carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A decoded byte is present this cycle |
| code_err | input | 1 | The decoder flagged this byte as corrupt |
| sync_code | input | 1 | This byte is the frame-boundary sync character |
| cfg_block_len | input | 16 | Bytes per judged block |
| cfg_good_blocks | input | 16 | Clean blocks needed to start hunting for a sync character |
| cfg_bad_blocks | input | 16 | Corrupt blocks that force the unaligned state |
| rate_sel | input | 3 | Line-rate factor i (1, 2 or 4) |
| state_o | output | 2 | Alignment state |
| link_up | output | 1 | Link is aligned |
| msg_pass | output | 1 | The current byte may be handed to the message layer |

## Verification
The bench aims at the length comparison in state 2. It sends a sync byte one byte early, one byte late, and then a sync byte that would match only if the early one had restarted the count. A design with an off-by-one or a restart on the failing byte would then align when it should not. It checks that a partial block is dropped at a state change: a design that keeps it merges an error into the following block and falls to state 0. It checks that a good block between bad ones resets the bad run, and that changing the rate after state 0 has no effect: a design that keeps sampling the rate would accept the wrong message length. Random streams with injected errors, length jitter and rate changes are compared byte by byte with a bench model of the requirements.

// File: rtl/frame_sync_rx.sv
module frame_sync_rx #(
  parameter int CW = 16,
  parameter int MW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic          code_err,
  input  logic          sync_code,
  input  logic [CW-1:0] cfg_block_len,
  input  logic [CW-1:0] cfg_good_blocks,
  input  logic [CW-1:0] cfg_bad_blocks,
  input  logic [2:0]    rate_sel,
  output logic [1:0]    state_o,
  output logic          link_up,
  output logic          msg_pass
);

  localparam logic [1:0] ST_UNSYNC = 2'd0;
  localparam logic [1:0] ST_HUNT   = 2'd1;
  localparam logic [1:0] ST_MSG    = 2'd2;
  localparam logic [1:0] ST_SYNC   = 2'd3;
  localparam logic [CW-1:0] RUN_MAX = '1;
  localparam logic [MW-1:0] MCNT_MAX = '1;

  logic [1:0]    state_q, state_d;
  logic [CW-1:0] bcnt_q, good_q, bad_q;
  logic          bbad_q;
  logic [MW-1:0] mcnt_q;
  logic [2:0]    rate_q;

  wire [CW-1:0] blk_len  = (cfg_block_len   == '0) ? CW'(1) : cfg_block_len;
  wire [CW-1:0] good_thr = (cfg_good_blocks == '0) ? CW'(1) : cfg_good_blocks;
  wire [CW-1:0] bad_thr  = (cfg_bad_blocks  == '0) ? CW'(1) : cfg_bad_blocks;
  wire [2:0]    rate_in  = (rate_sel == 3'd1 || rate_sel == 3'd2 || rate_sel == 3'd4) ? rate_sel : 3'd1;
  wire [MW-1:0] sync_m   = MW'({rate_q, 7'b0}) - MW'(1);

  wire          sync_hit = byte_vld & sync_code & ~code_err;
  wire          blk_end  = byte_vld && (bcnt_q == blk_len - CW'(1));
  wire          blk_bad  = bbad_q | code_err;
  wire          good_end = blk_end & ~blk_bad;
  wire          bad_end  = blk_end & blk_bad;
  wire [CW:0]   good_nx  = {1'b0, good_q} + 1'b1;
  wire [CW:0]   bad_nx   = {1'b0, bad_q} + 1'b1;
  wire          chg      = (state_d != state_q);

  always_comb begin
    state_d = state_q;
    if (bad_end && bad_nx >= {1'b0, bad_thr}) state_d = ST_UNSYNC;
    else if (byte_vld) begin
      case (state_q)
        ST_UNSYNC: if (good_end && good_nx >= {1'b0, good_thr}) state_d = ST_HUNT;
        ST_HUNT:   if (sync_hit) state_d = ST_MSG;
        ST_MSG:    if (sync_hit) state_d = (mcnt_q == sync_m) ? ST_SYNC : ST_HUNT;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_UNSYNC;
      bcnt_q  <= '0;
      bbad_q  <= 1'b0;
      good_q  <= '0;
      bad_q   <= '0;
      mcnt_q  <= '0;
      rate_q  <= 3'd1;
    end else begin
      state_q <= state_d;
      if (state_q == ST_UNSYNC) rate_q <= rate_in;
      if (byte_vld) begin
        if (blk_end || chg) begin
          bcnt_q <= '0;
          bbad_q <= 1'b0;
        end else begin
          bcnt_q <= bcnt_q + CW'(1);
          bbad_q <= blk_bad;
        end
        if (good_end) begin
          good_q <= (good_q == RUN_MAX) ? good_q : good_q + CW'(1);
          bad_q  <= '0;
        end else if (bad_end) begin
          bad_q  <= (bad_q == RUN_MAX) ? bad_q : bad_q + CW'(1);
          good_q <= '0;
        end
        if (state_d == ST_MSG && state_q != ST_MSG) mcnt_q <= '0;
        else if (state_q == ST_MSG && !sync_hit && mcnt_q != MCNT_MAX) mcnt_q <= mcnt_q + MW'(1);
      end
    end
  end

  assign state_o  = state_q;
  assign link_up  = (state_q == ST_SYNC);
  assign msg_pass = link_up & byte_vld & ~code_err;

  AST_SYNC_FROM_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SYNC && $past(state_q) != ST_SYNC) |-> $past(state_q) == ST_MSG); // R5
  AST_HUNT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT && $past(state_q) != ST_HUNT) |-> ($past(state_q) == ST_UNSYNC || $past(state_q) == ST_MSG)); // R3
  AST_MSG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MSG && $past(state_q) != ST_MSG) |-> $past(byte_vld && sync_code && !code_err)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(state_q)); // R11
  AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) != ST_UNSYNC) |-> $stable(rate_q)); // R6
  AST_PASS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pass |-> (byte_vld && state_o == ST_SYNC)); // R10

endmodule

// File: tb/frame_sync_rx_tb_top.sv
module frame_sync_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld = 1'b0, code_err = 1'b0, sync_code = 1'b0;
  logic [15:0] cfg_block_len = 16'd4, cfg_good_blocks = 16'd2, cfg_bad_blocks = 16'd2;
  logic [2:0] rate_sel = 3'd1;
  logic [1:0] state_o;
  logic link_up, msg_pass;

  always #2.5 clk = ~clk;

  frame_sync_rx dut_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .code_err(code_err), .sync_code(sync_code),
    .cfg_block_len(cfg_block_len), .cfg_good_blocks(cfg_good_blocks), .cfg_bad_blocks(cfg_bad_blocks),
    .rate_sel(rate_sel), .state_o(state_o), .link_up(link_up), .msg_pass(msg_pass)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_state, m_bcnt, m_bbad, m_good, m_bad, m_mcnt, m_rate;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int rate_of(input int r);
    return (r == 1 || r == 2 || r == 4) ? r : 1;
  endfunction

  function automatic void m_reset();
    m_state = 0; m_bcnt = 0; m_bbad = 0; m_good = 0; m_bad = 0; m_mcnt = 0; m_rate = 1;
  endfunction

  function automatic void m_clock(input bit v, input bit e, input bit s);
    int nst, blen, be, bb, sh;
    if (m_state == 0) m_rate = rate_of(int'(rate_sel));
    if (!v) return;
    blen = eff(int'(cfg_block_len));
    sh = (s && !e) ? 1 : 0;
    be = (m_bcnt == blen - 1) ? 1 : 0;
    bb = (m_bbad != 0 || e) ? 1 : 0;
    nst = m_state;
    if (be != 0 && bb != 0 && m_bad + 1 >= eff(int'(cfg_bad_blocks))) nst = 0;
    else case (m_state)
      0: if (be != 0 && bb == 0 && m_good + 1 >= eff(int'(cfg_good_blocks))) nst = 1;
      1: if (sh != 0) nst = 2;
      2: if (sh != 0) nst = (m_mcnt == 128 * m_rate - 1) ? 3 : 1;
      default: ;
    endcase
    if (nst == 2 && m_state != 2) m_mcnt = 0;
    else if (m_state == 2 && sh == 0 && m_mcnt < 1023) m_mcnt++;
    if (be != 0 || nst != m_state) begin m_bcnt = 0; m_bbad = 0; end
    else begin m_bcnt++; m_bbad = bb; end
    if (be != 0) begin
      if (bb != 0) begin if (m_bad < 65535) m_bad++; m_good = 0; end
      else begin if (m_good < 65535) m_good++; m_bad = 0; end
    end
    m_state = nst;
  endfunction

  task automatic check(input int act, input int exp, input string tag, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit v, input bit e, input bit s, input string tag);
    @(negedge clk);
    check(int'(state_o), m_state, tag, "state");
    check(int'(link_up), (m_state == 3) ? 1 : 0, "R10", "link_up");
    byte_vld = v; code_err = e; sync_code = s;
    #1;
    check(int'(msg_pass), (m_state == 3 && v && !e) ? 1 : 0, "R10", "msg_pass");
    @(posedge clk);
    m_clock(v, e, s);
    #1;
    byte_vld = 0; code_err = 0; sync_code = 0;
  endtask

  task automatic expect_state(input int exp, input string tag);
    #1;
    check(int'(state_o), exp, tag, "state");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; byte_vld = 0; code_err = 0; sync_code = 0;
    repeat (3) @(posedge clk);
    m_reset();
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic plain(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(1, 0, 0, tag);
  endtask

  task automatic reach_sync(input int plen);
    plain(8, "R3");
    cyc(1, 0, 1, "R4");
    plain(plen, "R5");
    cyc(1, 0, 1, "R5");
  endtask

  initial begin
    int seed_v, p, per, errw, nb;
    seed_v = $urandom(32'h1f2e3d4c);

    // reset state
    do_reset();
    expect_state(0, "R1");
    check(int'(link_up), 0, "R1", "link_up");
    check(int'(msg_pass), 0, "R1", "msg_pass");

    // two clean blocks of 4 -> hunting
    plain(7, "R3");
    expect_state(0, "R3");
    plain(1, "R3");
    expect_state(1, "R3");

    // partial block discarded on state change
    cyc(1, 1, 0, "R9");
    cyc(1, 0, 1, "R4");
    expect_state(2, "R4");
    cyc(1, 0, 0, "R9"); cyc(1, 0, 0, "R9"); cyc(1, 1, 0, "R9");
    plain(3, "R9");
    expect_state(2, "R9");
    plain(2, "R9");

    // early sync, no restart on that byte
    cyc(1, 0, 1, "R5");
    expect_state(1, "R5");
    plain(127, "R5");
    cyc(1, 0, 1, "R5");
    expect_state(2, "R5");
    plain(126, "R5");
    cyc(1, 0, 1, "R5");
    expect_state(1, "R5");
    cyc(1, 0, 1, "R4");
    plain(128, "R5");
    cyc(1, 0, 1, "R5");
    expect_state(1, "R5");
    cyc(1, 0, 1, "R4");
    plain(127, "R5");
    cyc(1, 0, 1, "R5");
    expect_state(3, "R5");
    check(int'(link_up), 1, "R10", "link_up");

    // idle cycles carry noise only
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); byte_vld = 0; code_err = 1; sync_code = 1;
      @(posedge clk); m_clock(0, 1, 1);
    end
    @(negedge clk); code_err = 0; sync_code = 0;
    expect_state(3, "R11");

    // outcome change clears runs, then bad run drops link
    do_reset();
    reach_sync(127);
    expect_state(3, "R5");
    cyc(1, 1, 0, "R10");
    cyc(1, 1, 0, "R8"); cyc(1, 1, 0, "R8"); cyc(1, 1, 0, "R8");
    plain(4, "R8");
    cyc(1, 1, 0, "R8"); cyc(1, 1, 0, "R8"); cyc(1, 1, 0, "R8"); cyc(1, 1, 0, "R8");
    expect_state(3, "R8");
    cyc(1, 1, 0, "R7"); cyc(1, 1, 0, "R7"); cyc(1, 1, 0, "R7");
    expect_state(3, "R7");
    cyc(1, 1, 0, "R7");
    expect_state(0, "R7");

    // clean, bad, clean blocks in unaligned state
    do_reset();
    plain(4, "R2");
    cyc(1, 0, 0, "R2"); cyc(1, 0, 0, "R2"); cyc(1, 1, 0, "R2"); cyc(1, 0, 0, "R2");
    plain(4, "R2");
    expect_state(0, "R2");
    plain(4, "R8");
    expect_state(1, "R8");

    // zero thresholds act as one
    cfg_block_len = 0; cfg_good_blocks = 0;
    do_reset();
    cyc(1, 1, 0, "R2");
    expect_state(0, "R2");
    cyc(1, 0, 0, "R2");
    expect_state(1, "R2");
    cfg_bad_blocks = 0;
    cyc(1, 1, 0, "R7");
    expect_state(0, "R7");
    cfg_block_len = 4; cfg_good_blocks = 2; cfg_bad_blocks = 2;

    // sync flag on a corrupt byte is ordinary
    do_reset();
    plain(8, "R3");
    cyc(1, 1, 1, "R4");
    expect_state(1, "R4");

    // rate sampled only while unaligned
    rate_sel = 3'd4;
    do_reset();
    plain(8, "R3");
    rate_sel = 3'd1;
    cyc(1, 0, 1, "R4");
    plain(127, "R6");
    cyc(1, 0, 1, "R6");
    expect_state(1, "R6");
    cyc(1, 0, 1, "R4");
    plain(511, "R6");
    cyc(1, 0, 1, "R6");
    expect_state(3, "R6");
    rate_sel = 3'd3;
    do_reset();
    reach_sync(127);
    expect_state(3, "R6");
    rate_sel = 3'd2;
    do_reset();
    reach_sync(255);
    expect_state(3, "R6");

    // constrained random episodes
    for (int ep = 0; ep < 16; ep++) begin
      cfg_block_len   = 16'($urandom_range(0, 8));
      cfg_good_blocks = 16'($urandom_range(0, 3));
      cfg_bad_blocks  = 16'($urandom_range(0, 3));
      rate_sel        = 3'($urandom_range(0, 7));
      per = 128 * rate_of(int'(rate_sel));
      errw = (ep % 3 == 0) ? 0 : ((ep % 3 == 1) ? 300 : 25);
      do_reset();
      p = 0;
      nb = 2500 + 300 * (ep % 4);
      for (int k = 0; k < nb; k++) begin
        bit v, e, s;
        v = ($urandom_range(0, 9) != 0);
        e = (errw != 0) && ($urandom_range(0, errw - 1) == 0);
        s = (p == 0);
        if ($urandom_range(0, 399) == 0) rate_sel = 3'($urandom_range(0, 7));
        cyc(v, e, s, "R5");
        if (v) begin
          if ($urandom_range(0, 149) != 0) p = (p + 1) % per;
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule